// File: doc/BRIEF.md
# Write-back Cache Coherence Line Controller

This block keeps the coherence state of every line in a small direct-mapped write-back cache on a snooping bus. On the processor side it accepts one read or write request per cycle. On the bus side it watches read snoops and ownership-read snoops from other caches. Its outputs are a fill request (plain read or ownership read), a write-back of an evicted dirty victim, a write-back (flush) of a dirty line that another cache is snooping, a shared-line response, and a hit indication. Data storage, memory and bus arbitration sit outside the block. It holds only tags and states.

Each line is Invalid, Shared or Modified. With `EXCL_EN` set, a fourth Exclusive state marks a clean line that no other cache holds. Such a line can be written without any bus traffic. When a snoop and a processor request arrive in the same cycle, the snoop is applied to the line first. The processor request is then evaluated against the state the snoop left behind. All outputs are registered. Each one is a one-cycle pulse in the cycle after the inputs that caused it.

Top module: `coherence_ctrl`

## Requirements
- R1: After reset every line is Invalid, every output is low, and the first access to any address misses.
- R2: A read that misses issues `busRd` with `busAddr` equal to the request address. The line then holds Exclusive if `EXCL_EN` is set and `busSharedIn` was low in the request cycle, and Shared otherwise.
- R3: A write that misses issues `busRdX` with `busAddr` equal to the request address, and the line becomes Modified.
- R4: A read that hits any valid line, and a write that hits a Modified or Exclusive line, raise `cpuHit` and cause no bus request. An Exclusive line that is written becomes Modified.
- R5: A write that hits a Shared line raises both `cpuHit` and `busRdX`, and the line becomes Modified.
- R6: A read snoop that matches a valid line raises `snpShared`. A Modified line also raises `snpFlush`. Modified and Exclusive lines end up Shared.
- R7: An ownership-read snoop that matches a valid line makes it Invalid. It raises `snpFlush` only when the line was Modified, and never raises `snpShared`. A snoop that matches no valid line gives no response and changes no state.
- R8: The address is split into a tag (upper bits) and a line index (low `$clog2(LINES)` bits). A miss on an index that holds a Modified line with a different tag raises `evictWb` with `evictAddr` equal to the victim's address, in the same cycle as the fill request. A clean victim is dropped silently.
- R9: When a snoop and a processor request hit the same line in one cycle, the snoop transition is applied first and the request acts on the resulting state.
- R10: With `EXCL_EN` cleared, read fills always end Shared, so the first write after a read fill issues `busRdX`.
- R11: Every output is a single-cycle pulse registered one cycle after its cause. `busRd` and `busRdX` are never raised together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | Processor request valid |
| cpuWr | input | 1 | Request is a write (else read) |
| cpuAddr | input | ADDR_W | Processor request address |
| snpValid | input | 1 | Snooped bus transaction valid |
| snpExcl | input | 1 | Snoop is an ownership read (else plain read) |
| snpAddr | input | ADDR_W | Snooped address |
| busSharedIn | input | 1 | Another cache reported holding the line being filled |
| cpuHit | output | 1 | Previous request hit a valid line |
| busRd | output | 1 | Issue a bus read for a fill |
| busRdX | output | 1 | Issue a bus ownership read |
| busAddr | output | ADDR_W | Address of the bus request, zero when none |
| evictWb | output | 1 | Write back a dirty victim |
| evictAddr | output | ADDR_W | Victim address, zero when none |
| snpFlush | output | 1 | Write back a dirty line for a snooper |
| snpShared | output | 1 | Drive the shared-line response for a read snoop |

## Verification
The bench targets four corner cases. The first is a silent Exclusive-to-Modified upgrade. A design that sent an ownership read there, or that failed to dirty the line, would later miss a flush. The second is a snoop and a processor write to the same line in one cycle. A design that ordered them the other way would skip the ownership read and keep a stale Modified line. The third is eviction of a dirty line by a fill to the same index. Dropping the write-back or reporting the new tag would lose data. The fourth is a snoop to an invalid or mismatched line, where any response would corrupt the other cache's view. A second instance with the Exclusive state disabled runs on the same stimulus to confirm that fills stay Shared.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHR = 2'd1,
    LS_EXC = 2'd2,
    LS_MOD = 2'd3
  } lineState_t;

  // strobes from protocol control to the line array / output registers
  typedef struct packed {
    logic       snpUpd;
    lineState_t snpNext;
    logic       cpuUpd;
    logic       cpuFill;
    lineState_t cpuNext;
    logic       reqRd;
    logic       reqRdX;
    logic       evict;
    logic       flush;
    logic       shared;
    logic       hit;
  } ctrlStrobe_t;

endpackage

// File: rtl/coh_line_array.sv
module coh_line_array #(
  parameter int LINES = 4,
  parameter int TAG_W = 4,
  localparam int IDX_W = $clog2(LINES),
  localparam int ADDR_W = TAG_W + IDX_W
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [ADDR_W-1:0]         cpuAddr,
  input  logic [ADDR_W-1:0]         snpAddr,
  input  coh_pkg::ctrlStrobe_t      st,
  output coh_pkg::lineState_t       cpuLineState,
  output logic                      cpuTagMatch,
  output coh_pkg::lineState_t       snpLineState,
  output logic                      snpTagMatch,
  output logic                      sameIdx,
  output logic                      cpuHit,
  output logic                      busRd,
  output logic                      busRdX,
  output logic [ADDR_W-1:0]         busAddr,
  output logic                      evictWb,
  output logic [ADDR_W-1:0]         evictAddr,
  output logic                      snpFlush,
  output logic                      snpShared
);
  import coh_pkg::*;

  logic [TAG_W-1:0] tagMem [LINES];
  lineState_t       stMem  [LINES];

  logic [IDX_W-1:0] cpuIdx, snpIdx;
  logic [TAG_W-1:0] cpuTag, snpTag;

  assign cpuIdx = cpuAddr[IDX_W-1:0];
  assign cpuTag = cpuAddr[ADDR_W-1:IDX_W];
  assign snpIdx = snpAddr[IDX_W-1:0];
  assign snpTag = snpAddr[ADDR_W-1:IDX_W];

  assign cpuLineState = stMem[cpuIdx];
  assign cpuTagMatch  = (tagMem[cpuIdx] == cpuTag);
  assign snpLineState = stMem[snpIdx];
  assign snpTagMatch  = (tagMem[snpIdx] == snpTag);
  assign sameIdx      = (cpuIdx == snpIdx);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < LINES; i++) begin
        stMem[i]  <= LS_INV;
        tagMem[i] <= '0;
      end
      cpuHit    <= 1'b0;
      busRd     <= 1'b0;
      busRdX    <= 1'b0;
      busAddr   <= '0;
      evictWb   <= 1'b0;
      evictAddr <= '0;
      snpFlush  <= 1'b0;
      snpShared <= 1'b0;
    end else begin
      // snoop update first; a processor update of the same line overrides it
      if (st.snpUpd)  stMem[snpIdx]  <= st.snpNext;
      if (st.cpuUpd)  stMem[cpuIdx]  <= st.cpuNext;
      if (st.cpuFill) tagMem[cpuIdx] <= cpuTag;
      cpuHit    <= st.hit;
      busRd     <= st.reqRd;
      busRdX    <= st.reqRdX;
      busAddr   <= (st.reqRd || st.reqRdX) ? cpuAddr : '0;
      evictWb   <= st.evict;
      evictAddr <= st.evict ? {tagMem[cpuIdx], cpuIdx} : '0;
      snpFlush  <= st.flush;
      snpShared <= st.shared;
    end
  end

endmodule

// File: rtl/coh_protocol_ctrl.sv
module coh_protocol_ctrl #(
  parameter bit EXCL_EN = 1'b1
) (
  input  logic                 cpuReq,
  input  logic                 cpuWr,
  input  logic                 snpValid,
  input  logic                 snpExcl,
  input  logic                 busSharedIn,
  input  coh_pkg::lineState_t  cpuLineState,
  input  logic                 cpuTagMatch,
  input  coh_pkg::lineState_t  snpLineState,
  input  logic                 snpTagMatch,
  input  logic                 sameIdx,
  output coh_pkg::ctrlStrobe_t st
);
  import coh_pkg::*;

  logic       snpHit;
  lineState_t snpNext;
  lineState_t cpuCur;
  logic       cpuHitNow;
  lineState_t fillRdState;

  assign snpHit    = snpValid && snpTagMatch && (snpLineState != LS_INV);
  assign snpNext   = snpExcl ? LS_INV : LS_SHR;
  // processor sees the line as the snoop leaves it
  assign cpuCur    = (snpHit && sameIdx) ? snpNext : cpuLineState;
  assign cpuHitNow = cpuTagMatch && (cpuCur != LS_INV);

  generate
    if (EXCL_EN) begin : g_excl
      assign fillRdState = busSharedIn ? LS_SHR : LS_EXC;
    end else begin : g_msi
      assign fillRdState = LS_SHR;
    end
  endgenerate

  always_comb begin
    st         = '0;
    st.snpUpd  = snpHit;
    st.snpNext = snpNext;
    st.flush   = snpHit && (snpLineState == LS_MOD);
    st.shared  = snpHit && !snpExcl;
    if (cpuReq) begin
      if (cpuHitNow) begin
        st.hit = 1'b1;
        if (cpuWr) begin
          st.cpuUpd  = (cpuCur != LS_MOD);
          st.cpuNext = LS_MOD;
          st.reqRdX  = (cpuCur == LS_SHR);
        end
      end else begin
        st.cpuUpd  = 1'b1;
        st.cpuFill = 1'b1;
        st.evict   = (cpuCur == LS_MOD);
        if (cpuWr) begin
          st.reqRdX  = 1'b1;
          st.cpuNext = LS_MOD;
        end else begin
          st.reqRd   = 1'b1;
          st.cpuNext = fillRdState;
        end
      end
    end
  end

endmodule

// File: rtl/coherence_ctrl.sv
module coherence_ctrl #(
  parameter int LINES   = 4,
  parameter int TAG_W   = 4,
  parameter bit EXCL_EN = 1'b1,
  localparam int IDX_W  = $clog2(LINES),
  localparam int ADDR_W = TAG_W + IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWr,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              snpValid,
  input  logic              snpExcl,
  input  logic [ADDR_W-1:0] snpAddr,
  input  logic              busSharedIn,
  output logic              cpuHit,
  output logic              busRd,
  output logic              busRdX,
  output logic [ADDR_W-1:0] busAddr,
  output logic              evictWb,
  output logic [ADDR_W-1:0] evictAddr,
  output logic              snpFlush,
  output logic              snpShared
);
  import coh_pkg::*;

  ctrlStrobe_t strobes;
  lineState_t  cpuLineState, snpLineState;
  logic        cpuTagMatch, snpTagMatch, sameIdx;

  coh_protocol_ctrl #(.EXCL_EN(EXCL_EN)) u_ctrl (
    .cpuReq      (cpuReq),
    .cpuWr       (cpuWr),
    .snpValid    (snpValid),
    .snpExcl     (snpExcl),
    .busSharedIn (busSharedIn),
    .cpuLineState(cpuLineState),
    .cpuTagMatch (cpuTagMatch),
    .snpLineState(snpLineState),
    .snpTagMatch (snpTagMatch),
    .sameIdx     (sameIdx),
    .st          (strobes)
  );

  coh_line_array #(.LINES(LINES), .TAG_W(TAG_W)) u_array (
    .clk         (clk),
    .rstN        (rstN),
    .cpuAddr     (cpuAddr),
    .snpAddr     (snpAddr),
    .st          (strobes),
    .cpuLineState(cpuLineState),
    .cpuTagMatch (cpuTagMatch),
    .snpLineState(snpLineState),
    .snpTagMatch (snpTagMatch),
    .sameIdx     (sameIdx),
    .cpuHit      (cpuHit),
    .busRd       (busRd),
    .busRdX      (busRdX),
    .busAddr     (busAddr),
    .evictWb     (evictWb),
    .evictAddr   (evictAddr),
    .snpFlush    (snpFlush),
    .snpShared   (snpShared)
  );

endmodule

// File: rtl/coherence_ctrl_chk.sv
module coherence_ctrl_chk #(
  parameter int ADDR_W = 6,
  parameter int IDX_W  = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuReq,
  input logic              cpuWr,
  input logic              snpValid,
  input logic              snpExcl,
  input logic              cpuHit,
  input logic              busRd,
  input logic              busRdX,
  input logic [ADDR_W-1:0] busAddr,
  input logic              evictWb,
  input logic [ADDR_W-1:0] evictAddr,
  input logic              snpFlush,
  input logic              snpShared
);

  a_r2_rd_from_read: assert property (@(posedge clk) disable iff (!rstN)
    busRd |-> $past(cpuReq && !cpuWr));

  a_r3_rdx_from_write: assert property (@(posedge clk) disable iff (!rstN)
    busRdX |-> $past(cpuReq && cpuWr));

  a_r4_hit_no_fill: assert property (@(posedge clk) disable iff (!rstN)
    cpuHit |-> !busRd);

  a_r6_shared_on_read_snoop: assert property (@(posedge clk) disable iff (!rstN)
    snpShared |-> $past(snpValid && !snpExcl));

  a_r7_flush_from_snoop: assert property (@(posedge clk) disable iff (!rstN)
    snpFlush |-> $past(snpValid));

  a_r8_evict_same_set: assert property (@(posedge clk) disable iff (!rstN)
    evictWb |-> ((busRd || busRdX) &&
                 evictAddr[IDX_W-1:0] == busAddr[IDX_W-1:0] &&
                 evictAddr != busAddr));

  a_r11_single_fill_kind: assert property (@(posedge clk) disable iff (!rstN)
    !(busRd && busRdX));

endmodule

bind coherence_ctrl coherence_ctrl_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cpuReq   (cpuReq),
  .cpuWr    (cpuWr),
  .snpValid (snpValid),
  .snpExcl  (snpExcl),
  .cpuHit   (cpuHit),
  .busRd    (busRd),
  .busRdX   (busRdX),
  .busAddr  (busAddr),
  .evictWb  (evictWb),
  .evictAddr(evictAddr),
  .snpFlush (snpFlush),
  .snpShared(snpShared)
);

// File: tb/coherence_ctrl_tb.sv
`timescale 1ns/1ps
module coherence_ctrl_tb;

  localparam int LINES  = 4;
  localparam int TAG_W  = 4;
  localparam int ADDR_W = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpuReq = 1'b0, cpuWr = 1'b0, snpValid = 1'b0, snpExcl = 1'b0, busSharedIn = 1'b0;
  logic [ADDR_W-1:0] cpuAddr = '0, snpAddr = '0;

  logic cpuHit, busRd, busRdX, evictWb, snpFlush, snpShared;
  logic [ADDR_W-1:0] busAddr, evictAddr;
  logic msiHit, msiRd, msiRdX, msiEvict, msiFlush, msiShared;
  logic [ADDR_W-1:0] msiBusAddr, msiEvictAddr;

  int checks = 0;
  int errors = 0;

  int mSt  [2][LINES];
  int mTag [2][LINES];
  logic [17:0] expA;
  logic [2:0]  expB;
  string       expTag;

  always #4 clk = ~clk;

  coherence_ctrl #(.LINES(LINES), .TAG_W(TAG_W), .EXCL_EN(1'b1)) u_dut (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWr(cpuWr), .cpuAddr(cpuAddr),
    .snpValid(snpValid), .snpExcl(snpExcl), .snpAddr(snpAddr), .busSharedIn(busSharedIn),
    .cpuHit(cpuHit), .busRd(busRd), .busRdX(busRdX), .busAddr(busAddr),
    .evictWb(evictWb), .evictAddr(evictAddr), .snpFlush(snpFlush), .snpShared(snpShared));

  coherence_ctrl #(.LINES(LINES), .TAG_W(TAG_W), .EXCL_EN(1'b0)) u_dutMsi (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWr(cpuWr), .cpuAddr(cpuAddr),
    .snpValid(snpValid), .snpExcl(snpExcl), .snpAddr(snpAddr), .busSharedIn(busSharedIn),
    .cpuHit(msiHit), .busRd(msiRd), .busRdX(msiRdX), .busAddr(msiBusAddr),
    .evictWb(msiEvict), .evictAddr(msiEvictAddr), .snpFlush(msiFlush), .snpShared(msiShared));

  task automatic check(bit ok, string req, logic [17:0] act, logic [17:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [17:0] packMain();
    return {busRd, busRdX, busAddr, evictWb, evictAddr, snpFlush, snpShared, cpuHit};
  endfunction

  // reference model: instance 0 has the Exclusive state, instance 1 does not
  task automatic predict(bit rq, bit wr, int ca, bit sv, bit sx, int sa, bit shIn);
    expTag = "R11";
    for (int k = 0; k < 2; k++) begin
      int si = sa % LINES; int stg = sa / LINES;
      int ci = ca % LINES; int ctg = ca / LINES;
      bit fl = 0, sh = 0, rd = 0, rdx = 0, ev = 0, ht = 0, sHit = 0;
      int evA = 0;
      string tg = "R11";
      if (sv) begin
        tg = sx ? "R7" : "R6";
        if (mSt[k][si] != 0 && mTag[k][si] == stg) begin
          sHit = 1;
          fl = (mSt[k][si] == 3);
          sh = !sx;
          mSt[k][si] = sx ? 0 : 1;
        end
      end
      if (rq) begin
        if (mSt[k][ci] != 0 && mTag[k][ci] == ctg) begin
          ht = 1;
          if (wr) begin
            if (mSt[k][ci] == 1) begin rdx = 1; tg = "R5"; end else tg = "R4";
            mSt[k][ci] = 3;
          end else tg = "R4";
        end else begin
          if (mSt[k][ci] == 3) begin ev = 1; evA = mTag[k][ci] * LINES + ci; tg = "R8"; end
          else tg = wr ? "R3" : "R2";
          mTag[k][ci] = ctg;
          if (wr) begin rdx = 1; mSt[k][ci] = 3; end
          else begin rd = 1; mSt[k][ci] = (k == 0 && !shIn) ? 2 : 1; end
        end
        if (sHit && si == ci) tg = "R9";
      end
      if (k == 0) begin
        expA = {rd, rdx, 6'((rd || rdx) ? ca : 0), ev, 6'(evA), fl, sh, ht};
        expTag = tg;
      end else expB = {rd, rdx, ht};
    end
  endtask

  task automatic doStep(bit rq, bit wr, int ca, bit sv, bit sx, int sa, bit shIn);
    cpuReq = rq; cpuWr = wr; cpuAddr = 6'(ca);
    snpValid = sv; snpExcl = sx; snpAddr = 6'(sa); busSharedIn = shIn;
    predict(rq, wr, ca, sv, sx, sa, shIn);
    @(negedge clk);
    check(packMain() == expA, expTag, packMain(), expA);
    // R10: the instance without the Exclusive state
    check({msiRd, msiRdX, msiHit} == expB, "R10", 18'({msiRd, msiRdX, msiHit}), 18'(expB));
  endtask

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < 2; k++)
      for (int i = 0; i < LINES; i++) begin mSt[k][i] = 0; mTag[k][i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state, all outputs low
    check(packMain() == '0, "R1", packMain(), '0);
    check({msiRd, msiRdX, msiHit, msiEvict, msiFlush, msiShared} == '0, "R1",
          18'({msiRd, msiRdX, msiHit, msiEvict, msiFlush, msiShared}), '0);

    // directed corners
    doStep(1, 0, 6, 0, 0, 0, 0);   // R2 read miss, no sharer -> Exclusive
    doStep(1, 1, 6, 0, 0, 0, 0);   // R4 silent E->M write
    doStep(0, 0, 0, 1, 0, 6, 0);   // R6 read snoop of Modified: flush, -> Shared
    doStep(1, 1, 6, 0, 0, 0, 0);   // R5 write on Shared: ownership read
    doStep(0, 0, 0, 1, 1, 6, 0);   // R7 ownership snoop of Modified: flush, -> Invalid
    doStep(0, 0, 0, 1, 0, 6, 0);   // R7 snoop to invalid line ignored
    doStep(1, 0, 6, 0, 0, 0, 1);   // R2 read miss with sharer -> Shared
    doStep(1, 1, 10, 0, 0, 0, 0);  // R3 write miss, clean victim dropped
    doStep(1, 0, 14, 0, 0, 0, 0);  // R8 dirty victim written back
    doStep(1, 1, 1, 0, 0, 0, 0);   // R3 write miss
    doStep(1, 1, 1, 1, 0, 1, 0);   // R9 snoop first, then write upgrade
    doStep(0, 0, 0, 0, 0, 0, 0);   // R11 pulses drop
    doStep(0, 0, 0, 0, 0, 0, 0);

    void'($urandom(32'h5eed_c0de));
    for (int n = 0; n < 600; n++) begin
      int ca = ($urandom % 4) * LINES + ($urandom % LINES);
      int sa = ($urandom % 4) * LINES + ($urandom % LINES);
      doStep($urandom % 4 != 0, $urandom % 2 == 1, ca,
             $urandom % 3 == 0, $urandom % 2 == 1, sa, $urandom % 2 == 1);
    end
    doStep(0, 0, 0, 0, 0, 0, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule